// File: doc/BRIEF.md
# Multiplexed Bus Fetch Monitor

This block watches the external program-memory bus of a small microcontroller without driving it. On that bus one 8-bit set of lines carries first the low address byte and later the fetched instruction byte. Five further lines carry address bits 8 to 12. An address strobe marks the address phase and an active-low read strobe marks the data phase. All bus pins are brought into the monitor's clock domain through two-flop synchronizers. Strobe edges are found by comparing each synchronized strobe with its value one clock earlier.

When the address strobe falls, the monitor forms a 13-bit address from the upper lines and the shared lines. When the read strobe returns high, it takes the shared lines as the data byte. Each completed fetch produces a record. The record appears as a parallel address/data word qualified by a one-cycle pulse. It is also sent as three bytes on a valid/ready byte stream, for a logger or trace buffer. No record is produced until an address has been seen after reset.

Top module: `fetch_bus_monitor`

## Requirements
- R1: A synchronous active-high reset clears rec_valid, byte_valid, overflow, rec_addr and rec_data to zero, and it clears the internal started state.
- R2: On a high-to-low change of ale, rec_addr takes {hi_addr, bus} as sampled together with that change.
- R3: On a low-to-high change of prog_rd_n, rec_data takes the bus value. If an address has been latched, rec_valid is then high for exactly one cycle, with rec_addr and rec_data holding the record.
- R4: Before the first falling ale after reset, a rising prog_rd_n still updates rec_data but produces no rec_valid pulse and no serial byte.
- R5: When a falling ale and a rising prog_rd_n are seen in the same cycle, the address is latched first, and the record carries the new address.
- R6: Several rising prog_rd_n edges with no falling ale between them each produce a record, and all of those records carry the last latched address.
- R7: Each record leaves on the byte stream in this order: {3'b000, addr[12:8]}, then addr[7:0], then the data byte. byte_valid and byte_data hold steady while byte_ready is low, and each cycle with byte_valid and byte_ready both high moves on by one byte.
- R8: A record produced while a previous record is still being sent is still shown on the parallel output. It is dropped from the byte stream, and overflow goes high and stays high until reset.
- R9: rec_valid goes high at the third rising clock edge after the prog_rd_n input rises.
- R10: A rising ale or a falling prog_rd_n produces no record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| bus | input | 8 | Shared low-address/data lines |
| hi_addr | input | 5 | Address lines 8 to 12 |
| ale | input | 1 | Address strobe; the address is taken on its falling edge |
| prog_rd_n | input | 1 | Active-low program read strobe; data is taken on its rising edge |
| rec_valid | output | 1 | One-cycle pulse marking a new record |
| rec_addr | output | 13 | Last latched fetch address |
| rec_data | output | 8 | Last captured data byte |
| byte_valid | output | 1 | Serial record byte available |
| byte_data | output | 8 | Serial record byte |
| byte_ready | input | 1 | Consumer accepts the current byte |
| overflow | output | 1 | Sticky: a record was dropped from the byte stream |

## Verification
The assertions assume that the strobes come from a real bus. Each strobe level is held for at least two clocks. The shared lines and upper address lines stay stable for at least one clock before and after every strobe change, so the synchronized address or data lines up with the synchronized edge. The stimulus holds every strobe level for four clocks. It changes the bus lines only while both strobes are steady. In the same-cycle case it moves both strobes at one instant over one bus value. byte_ready is treated as unconstrained, and it is held low on purpose to test stalls and overflow.

// File: rtl/fetch_bus_monitor.sv
module fetch_bus_monitor #(
  parameter int HI_BITS = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [7:0]         bus,
  input  logic [HI_BITS-1:0] hi_addr,
  input  logic               ale,
  input  logic               prog_rd_n,
  output logic               rec_valid,
  output logic [HI_BITS+7:0] rec_addr,
  output logic [7:0]         rec_data,
  output logic               byte_valid,
  output logic [7:0]         byte_data,
  input  logic               byte_ready,
  output logic               overflow
);
  // HI_BITS must not exceed 8: the record reserves two bytes for the address
  localparam int AW  = HI_BITS + 8;
  localparam int NP  = AW + 2;
  localparam int PAD = 16 - AW;
  localparam logic [NP-1:0] IDLE = {1'b1, 1'b0, {AW{1'b0}}};

  logic [NP-1:0] s1, s2, s3;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic          started;
  logic [1:0]    cnt;
  logic [23:0]   sbuf;

  wire ale_fall   = s3[AW] & ~s2[AW];
  wire psen_rise  = ~s3[AW+1] & s2[AW+1];
  wire [AW-1:0] addr_nx = ale_fall ? s2[AW-1:0] : addr_q;
  wire started_nx = started | ale_fall;
  wire fire       = psen_rise & started_nx;
  wire busy       = |cnt;
  wire take       = busy & byte_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= IDLE;
      s2 <= IDLE;
      s3 <= IDLE;
    end else begin
      s1 <= {prog_rd_n, ale, hi_addr, bus};
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q    <= '0;
      data_q    <= '0;
      started   <= 1'b0;
      rec_valid <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      addr_q    <= addr_nx;
      started   <= started_nx;
      rec_valid <= fire;
      if (psen_rise) data_q <= s2[7:0];
      if (fire && busy) overflow <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      sbuf <= '0;
    end else if (fire && !busy) begin
      cnt  <= 2'd3;
      sbuf <= {{PAD{1'b0}}, addr_nx, s2[7:0]};
    end else if (take) begin
      cnt  <= cnt - 2'd1;
      sbuf <= {sbuf[15:0], 8'h00};
    end
  end

  assign rec_addr   = addr_q;
  assign rec_data   = data_q;
  assign byte_valid = busy;
  assign byte_data  = sbuf[23:16];
endmodule

// File: rtl/fetch_bus_monitor_chk.sv
module fetch_bus_monitor_chk (
  input logic       clk,
  input logic       rst,
  input logic       rec_valid,
  input logic       started,
  input logic       byte_valid,
  input logic [7:0] byte_data,
  input logic       byte_ready,
  input logic       overflow
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!rec_valid && !byte_valid && !overflow));

  p_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    rec_valid |=> !rec_valid);

  p_gate_start_r4: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> started);

  p_byte_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && !byte_ready) |=> (byte_valid && $stable(byte_data)));

  p_overflow_set_r8: assert property (@(posedge clk) disable iff (rst)
    byte_valid |=> (!rec_valid || overflow));

  p_no_overflow_clear_r8: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
endmodule

bind fetch_bus_monitor fetch_bus_monitor_chk i_chk (
  .clk(clk), .rst(rst), .rec_valid(rec_valid), .started(started),
  .byte_valid(byte_valid), .byte_data(byte_data),
  .byte_ready(byte_ready), .overflow(overflow)
);

// File: tb/test_fetch_bus_monitor.sv
module test_fetch_bus_monitor;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst = 1'b1;
  logic [7:0]  bus = '0;
  logic [4:0]  hi_addr = '0;
  logic        ale = 1'b0;
  logic        prog_rd_n = 1'b1;
  logic        byte_ready = 1'b1;
  logic        rec_valid, byte_valid, overflow;
  logic [12:0] rec_addr;
  logic [7:0]  rec_data, byte_data;

  int n_chk = 0;
  int n_bad = 0;

  fetch_bus_monitor i_fetch_bus_monitor (
    .clk(clk), .rst(rst), .bus(bus), .hi_addr(hi_addr), .ale(ale),
    .prog_rd_n(prog_rd_n), .rec_valid(rec_valid), .rec_addr(rec_addr),
    .rec_data(rec_data), .byte_valid(byte_valid), .byte_data(byte_data),
    .byte_ready(byte_ready), .overflow(overflow)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic quiet(input int n, input string req);
    int hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rec_valid || byte_valid) hits++;
    end
    chk(req, hits, 0);
  endtask

  task automatic wait_rec(output int lat);
    lat = 0;
    while (!rec_valid && lat < 20) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic collect(output logic [23:0] got);
    int nb = 0;
    got = '0;
    byte_ready = 1'b1;
    for (int i = 0; i < 30 && nb < 3; i++) begin
      if (byte_valid) begin
        got = {got[15:0], byte_data};
        nb++;
      end
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; ale = 1'b0; prog_rd_n = 1'b1; bus = '0; hi_addr = '0;
    byte_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rec_valid", rec_valid, 0);
    chk("R1 byte_valid", byte_valid, 0);
    chk("R1 overflow", overflow, 0);
    chk("R1 rec_addr", rec_addr, 0);
    chk("R1 rec_data", rec_data, 0);
  endtask

  task automatic latch_addr(input logic [12:0] a);
    bus = a[7:0]; hi_addr = a[12:8]; ale = 1'b1;
    quiet(4, "R10 ale rise");
    ale = 1'b0;
    quiet(4, "R10 ale fall alone");
    chk("R2 rec_addr", rec_addr, a);
  endtask

  task automatic psen_pulse(input logic [7:0] d, output int lat);
    bus = d; prog_rd_n = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk("R10 read fall", rec_valid, 0);
    end
    prog_rd_n = 1'b1;
    wait_rec(lat);
  endtask

  task automatic t_prestart();
    int lat;
    psen_pulse(8'h5A, lat);
    chk("R4 no record", rec_valid, 0);
    quiet(6, "R4 quiet");
    chk("R4 rec_data", rec_data, 8'h5A);
  endtask

  task automatic t_fetch(input logic [12:0] a, input logic [7:0] d);
    int lat;
    logic [23:0] got;
    logic [7:0] b0;
    latch_addr(a);
    byte_ready = 1'b0;
    psen_pulse(d, lat);
    chk("R9 latency", lat, 3);
    chk("R3 rec_addr", rec_addr, a);
    chk("R3 rec_data", rec_data, d);
    b0 = byte_data;
    @(negedge clk);
    chk("R3 one-cycle pulse", rec_valid, 0);
    chk("R7 held valid", byte_valid, 1);
    chk("R7 held data", byte_data, b0);
    collect(got);
    chk("R7 byte order", got, {3'b000, a, d});
  endtask

  task automatic t_repeat();
    int lat;
    logic [23:0] got;
    latch_addr(13'h0123);
    psen_pulse(8'h11, lat);
    chk("R6 first", {rec_addr, rec_data}, {13'h0123, 8'h11});
    collect(got);
    psen_pulse(8'h22, lat);
    chk("R6 seen", rec_valid, 1);
    chk("R6 reuse addr", {rec_addr, rec_data}, {13'h0123, 8'h22});
    collect(got);
    chk("R6 serial", got, {3'b000, 13'h0123, 8'h22});
  endtask

  task automatic t_same();
    int lat;
    logic [23:0] got;
    bus = 8'h3C; hi_addr = 5'h1F; ale = 1'b1; prog_rd_n = 1'b0;
    repeat (4) @(negedge clk);
    ale = 1'b0; prog_rd_n = 1'b1;
    wait_rec(lat);
    chk("R5 seen", rec_valid, 1);
    chk("R5 new addr", rec_addr, 13'h1F3C);
    chk("R5 data", rec_data, 8'h3C);
    collect(got);
    chk("R5 serial", got, {3'b000, 13'h1F3C, 8'h3C});
  endtask

  task automatic t_overflow();
    int lat;
    logic [23:0] got;
    latch_addr(13'h0456);
    byte_ready = 1'b0;
    psen_pulse(8'h99, lat);
    chk("R8 first rec", rec_valid, 1);
    psen_pulse(8'hAA, lat);
    chk("R8 parallel kept", rec_valid, 1);
    chk("R8 parallel data", rec_data, 8'hAA);
    chk("R8 overflow set", overflow, 1);
    collect(got);
    chk("R8 first record sent", got, {3'b000, 13'h0456, 8'h99});
    quiet(5, "R8 second dropped");
    chk("R8 sticky", overflow, 1);
    do_reset();
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    t_prestart();
    t_fetch(13'h1ABC, 8'hE1);
    t_fetch(13'h0042, 8'h7F);
    t_fetch(13'h1FFF, 8'h00);
    t_repeat();
    t_same();
    t_overflow();
    t_fetch(13'h0A5A, 8'hC3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule